// File: doc/BRIEF.md
# PWM Fault Recovery Controller

This block sits in the path from a PWM generator to its output pins. It watches four fault sources: a debug-halt request, two external fault pins and an analog comparator trip. While any of them is active, it takes every PWM output away from the generator and drives a programmable safe level instead. Each source leaves a sticky flag that software clears by writing a one to the flag's position. Three of the sources can also raise a level interrupt.

The way the outputs come back is chosen per source in an 8-bit control register, as either automatic or software-controlled recovery. Automatic recovery returns the outputs once every source is inactive. After a debug fault it also waits for a period-start strobe from the PWM timer. Software recovery also needs all flags cleared and a reload strobe. If any source set to software recovery took part in a fault event, software recovery governs that whole event.

Top module: `pwm_fault_guard`

## Requirements
- R1: After reset the control register and all four flags read zero, `irq` is low and `pwmOut` equals `pwmIn`.
- R2: A write to the control register takes effect at the clock edge where `cfgWe` is high, and all 8 bits read back on `cfgRdata` from then on. Bit 7 is stored but has no effect on any output. Recovery mode bits (0 automatic, 1 software): bit 6 debug, bit 0 fault pin 0, bit 4 fault pin 1, bit 2 comparator. Interrupt enables (1 enabled): bit 1 fault pin 0, bit 5 fault pin 1, bit 3 comparator.
- R3: Every fault input passes through a two-stage synchronizer. A raw assertion present before clock edge k does not affect `pwmOut` after edge k, and it forces the outputs after edge k+1.
- R4: While any synchronized source is active, every bit of `pwmOut` equals `safeLevel`.
- R5: Flag positions are bit 0 debug, bit 1 fault pin 0, bit 2 fault pin 1 and bit 3 comparator. A rising edge of a source sets its flag at edge k+2 of R3. A flag stays set until a clock edge with `clrWe` high and a one in its `clrMask` position. When a set and a clear meet in the same cycle, the set wins.
- R6: In an event with no software-mode source and no debug source, the outputs return to `pwmIn` at the clock edge after the first cycle in which all synchronized sources are inactive. That is the third edge after the last raw deassertion.
- R7: After a debug fault in automatic mode, the outputs stay forced until a clock edge with `periodStart` high and all sources inactive.
- R8: After a fault from a software-mode source, the outputs return only at a clock edge with `reloadStrobe` high, all sources inactive and the flag register already zero. A reload before the flags are cleared does not release them.
- R9: The recovery mode of a source is sampled at the edge that sets its flag. If any software-mode source took part in the event, software recovery applies to the whole event, and later changes to the control register do not change this.
- R10: `irq` is the OR over the flags of each flag ANDed with its enable bit from R2. The debug flag never raises `irq`. `irq` stays high until the enabling flag is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| dbgHalt | input | 1 | Debug-halt fault request (asynchronous) |
| faultIn0 | input | 1 | External fault pin 0 (asynchronous) |
| faultIn1 | input | 1 | External fault pin 1 (asynchronous) |
| cmpTrip | input | 1 | Comparator trip (asynchronous) |
| periodStart | input | 1 | Strobe from the PWM timer at the start of a period |
| reloadStrobe | input | 1 | Strobe from the PWM timer on a reload |
| cfgWe | input | 1 | Control register write enable |
| cfgWdata | input | 8 | Control register write data |
| cfgRdata | output | 8 | Control register contents |
| clrWe | input | 1 | Flag clear strobe |
| clrMask | input | 4 | Write-one-to-clear mask for the flags |
| flags | output | 4 | Sticky fault flags |
| pwmIn | input | OUT_W | Outputs from the PWM generator |
| safeLevel | input | OUT_W | Level driven while the outputs are forced |
| pwmOut | output | OUT_W | Outputs toward the pins |
| irq | output | 1 | Level interrupt request |

## Verification
A raw fault level reaches the output gate two edges after it is driven, and the flag one edge later. Automatic release comes three edges after the raw deassertion. A release by period start or by reload comes at the first edge where its strobe is sampled with the remaining conditions met. `irq`, `flags` and `cfgRdata` change one edge after the write or event that causes them. The bench drives inputs on the falling edge and runs a behavioural model that advances on every rising edge. It compares all outputs late in the low phase of each cycle. Directed checks count edges from the drive point and sample at exactly the edge where R3, R5, R6, R7 and R8 say a change is due, and one edge before it.

// File: rtl/pfg_pkg.sv
package pfg_pkg;
  localparam int SRC_N   = 4;
  localparam int SRC_DBG = 0;
  localparam int SRC_F0  = 1;
  localparam int SRC_F1  = 2;
  localparam int SRC_CMP = 3;
  localparam int CFG_W   = 8;

  // status from datapath to control
  typedef struct packed {
    logic             anyActive;
    logic             flagsZero;
    logic [SRC_N-1:0] rise;
  } pfg_status_t;

  // strobes from control to datapath
  typedef struct packed {
    logic forceSafe;
    logic releaseNow;
  } pfg_ctrl_t;

  // recovery mode per source: 1 = software recovery
  function automatic logic [SRC_N-1:0] modeSelect(input logic [CFG_W-1:0] c);
    return {c[2], c[4], c[0], c[6]};
  endfunction

  // interrupt enable per source, debug has none
  function automatic logic [SRC_N-1:0] irqEnables(input logic [CFG_W-1:0] c);
    return {c[3], c[5], c[1], 1'b0};
  endfunction
endpackage

// File: rtl/pfg_datapath.sv
module pfg_datapath
  import pfg_pkg::*;
#(
  parameter int OUT_W       = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [SRC_N-1:0]  faultRaw,
  input  logic              cfgWe,
  input  logic [CFG_W-1:0]  cfgWdata,
  input  logic              clrWe,
  input  logic [SRC_N-1:0]  clrMask,
  input  logic [OUT_W-1:0]  pwmIn,
  input  logic [OUT_W-1:0]  safeLevel,
  input  pfg_ctrl_t         ctl,
  output pfg_status_t       status,
  output logic [SRC_N-1:0]  modeVec,
  output logic [CFG_W-1:0]  cfgQ,
  output logic [SRC_N-1:0]  flagsQ,
  output logic [OUT_W-1:0]  pwmOut,
  output logic              irq
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0][SRC_N-1:0] syncChain;
  logic [SRC_N-1:0] syncQ;
  logic [SRC_N-1:0] prevQ;
  logic [SRC_N-1:0] riseVec;
  logic [SRC_N-1:0] flagNext;
  logic [SRC_N-1:0] clrVec;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncChain <= '0;
      prevQ     <= '0;
    end else begin
      syncChain[0] <= faultRaw;
      for (int s = 1; s < SYNC_STAGES; s++) syncChain[s] <= syncChain[s-1];
      prevQ <= syncQ;
    end
  end

  assign syncQ   = syncChain[LAST];
  assign riseVec = syncQ & ~prevQ;
  assign clrVec  = clrWe ? clrMask : '0;

  generate
    for (genvar g = 0; g < SRC_N; g++) begin : g_flag
      assign flagNext[g] = riseVec[g] | (flagsQ[g] & ~clrVec[g]);

      p_flag_sticky_r5: assert property (@(posedge clk) disable iff (!rstN)
        flagsQ[g] && !(clrWe && clrMask[g]) |=> flagsQ[g]);
      p_rise_sets_flag_r5: assert property (@(posedge clk) disable iff (!rstN)
        riseVec[g] |=> flagsQ[g]);
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagsQ <= '0;
      cfgQ   <= '0;
    end else begin
      flagsQ <= flagNext;
      if (cfgWe) cfgQ <= cfgWdata;
    end
  end

  assign status.anyActive = |syncQ;
  assign status.flagsZero = (flagsQ == '0);
  assign status.rise      = riseVec;
  assign modeVec          = modeSelect(cfgQ);
  assign irq              = |(flagsQ & irqEnables(cfgQ));
  assign pwmOut           = ctl.forceSafe ? safeLevel : pwmIn;

  p_safe_when_active_r4: assert property (@(posedge clk) disable iff (!rstN)
    status.anyActive |-> pwmOut == safeLevel);
  p_irq_level_r10: assert property (@(posedge clk) disable iff (!rstN)
    irq && !clrWe && !cfgWe |=> irq);
  p_irq_has_flag_r10: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> flagsQ != '0);
endmodule

// File: rtl/pfg_ctrl.sv
module pfg_ctrl
  import pfg_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  pfg_status_t      status,
  input  logic [SRC_N-1:0] modeVec,
  input  logic             periodStart,
  input  logic             reloadStrobe,
  output pfg_ctrl_t        ctl
);
  logic pendingQ;
  logic swEventQ;
  logic dbgEventQ;
  logic releaseOk;

  always_comb begin
    if (swEventQ)       releaseOk = status.flagsZero && reloadStrobe;
    else if (dbgEventQ) releaseOk = periodStart;
    else                releaseOk = 1'b1;
  end

  assign ctl.releaseNow = pendingQ && !status.anyActive && releaseOk;
  assign ctl.forceSafe  = status.anyActive || pendingQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendingQ  <= 1'b0;
      swEventQ  <= 1'b0;
      dbgEventQ <= 1'b0;
    end else if (status.anyActive) begin
      pendingQ  <= 1'b1;
      swEventQ  <= swEventQ | (|(status.rise & modeVec));
      dbgEventQ <= dbgEventQ | status.rise[SRC_DBG];
    end else if (ctl.releaseNow) begin
      pendingQ  <= 1'b0;
      swEventQ  <= 1'b0;
      dbgEventQ <= 1'b0;
    end
  end

  p_sw_needs_reload_r8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(pendingQ) && $past(swEventQ) |-> $past(reloadStrobe) && $past(status.flagsZero));
  p_dbg_needs_period_r7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(pendingQ) && $past(dbgEventQ) && !$past(swEventQ) |-> $past(periodStart));
  p_release_only_idle_r6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(pendingQ) |-> !$past(status.anyActive));
endmodule

// File: rtl/pwm_fault_guard.sv
module pwm_fault_guard
  import pfg_pkg::*;
#(
  parameter int OUT_W       = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             dbgHalt,
  input  logic             faultIn0,
  input  logic             faultIn1,
  input  logic             cmpTrip,
  input  logic             periodStart,
  input  logic             reloadStrobe,
  input  logic             cfgWe,
  input  logic [7:0]       cfgWdata,
  output logic [7:0]       cfgRdata,
  input  logic             clrWe,
  input  logic [3:0]       clrMask,
  output logic [3:0]       flags,
  input  logic [OUT_W-1:0] pwmIn,
  input  logic [OUT_W-1:0] safeLevel,
  output logic [OUT_W-1:0] pwmOut,
  output logic             irq
);
  pfg_status_t      status;
  pfg_ctrl_t        ctl;
  logic [SRC_N-1:0] modeVec;
  logic [SRC_N-1:0] faultRaw;

  assign faultRaw = {cmpTrip, faultIn1, faultIn0, dbgHalt};

  pfg_datapath #(.OUT_W(OUT_W), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .faultRaw(faultRaw),
    .cfgWe(cfgWe), .cfgWdata(cfgWdata), .clrWe(clrWe), .clrMask(clrMask),
    .pwmIn(pwmIn), .safeLevel(safeLevel), .ctl(ctl), .status(status),
    .modeVec(modeVec), .cfgQ(cfgRdata), .flagsQ(flags), .pwmOut(pwmOut), .irq(irq)
  );

  pfg_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .status(status), .modeVec(modeVec),
    .periodStart(periodStart), .reloadStrobe(reloadStrobe), .ctl(ctl)
  );
endmodule

// File: tb/pwm_fault_guard_tb_top.sv
module pwm_fault_guard_tb_top;
  timeunit 1ns; timeprecision 1ns;
  localparam int OUT_W = 6;
  localparam logic [OUT_W-1:0] PWM_A = 6'b101010;
  localparam logic [OUT_W-1:0] SAFE  = 6'b000111;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rstN = 1'b0;
  logic dbgHalt = 0, faultIn0 = 0, faultIn1 = 0, cmpTrip = 0;
  logic periodStart = 0, reloadStrobe = 0, cfgWe = 0, clrWe = 0;
  logic [7:0] cfgWdata = '0;
  logic [3:0] clrMask = '0;
  logic [OUT_W-1:0] pwmIn = PWM_A, safeLevel = SAFE;
  logic [7:0] cfgRdata;
  logic [3:0] flags;
  logic [OUT_W-1:0] pwmOut;
  logic irq;

  int checks = 0, fails = 0;
  string phase = "R1";

  pwm_fault_guard #(.OUT_W(OUT_W)) dut_i (
    .clk(clk), .rstN(rstN), .dbgHalt(dbgHalt), .faultIn0(faultIn0), .faultIn1(faultIn1),
    .cmpTrip(cmpTrip), .periodStart(periodStart), .reloadStrobe(reloadStrobe),
    .cfgWe(cfgWe), .cfgWdata(cfgWdata), .cfgRdata(cfgRdata), .clrWe(clrWe),
    .clrMask(clrMask), .flags(flags), .pwmIn(pwmIn), .safeLevel(safeLevel),
    .pwmOut(pwmOut), .irq(irq)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  // behavioural reference model
  logic [3:0] mS1 = 0, mS2 = 0, mPrev = 0, mFlags = 0, mRise, mMode;
  logic mPend = 0, mSw = 0, mDbg = 0, mOk;
  logic [7:0] mCfg = 0;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mS1 = 0; mS2 = 0; mPrev = 0; mFlags = 0; mPend = 0; mSw = 0; mDbg = 0; mCfg = 0;
    end else begin
      mRise = mS2 & ~mPrev;
      mMode = {mCfg[2], mCfg[4], mCfg[0], mCfg[6]};
      if (mS2 != 0) begin
        mPend = 1;
        if ((mRise & mMode) != 0) mSw = 1;
        if (mRise[0]) mDbg = 1;
      end else if (mPend) begin
        mOk = mSw ? (mFlags == 0 && reloadStrobe) : (mDbg ? periodStart : 1'b1);
        if (mOk) begin mPend = 0; mSw = 0; mDbg = 0; end
      end
      mFlags = (mFlags & ~(clrWe ? clrMask : 4'h0)) | mRise;
      if (cfgWe) mCfg = cfgWdata;
      mPrev = mS2; mS2 = mS1; mS1 = {cmpTrip, faultIn1, faultIn0, dbgHalt};
    end
  end

  always @(negedge clk) begin
    #8;
    if (rstN) begin
      chk(phase, "model pwmOut", pwmOut, ((mS2 != 0) || mPend) ? safeLevel : pwmIn);
      chk(phase, "model flags", flags, mFlags);
      chk(phase, "model irq", irq, |(mFlags & {mCfg[3], mCfg[5], mCfg[1], 1'b0}));
      chk(phase, "model cfgRdata", cfgRdata, mCfg);
    end
  end

  task automatic step(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfgWrite(input logic [7:0] v);
    cfgWe = 1; cfgWdata = v; step(); cfgWe = 0;
  endtask

  task automatic clearFlags(input logic [3:0] m);
    clrWe = 1; clrMask = m; step(); clrWe = 0; clrMask = 0;
  endtask

  initial begin
    #4000000;
    checks++; fails++;
    $display("FAIL R1 watchdog act=running exp=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    step(3); rstN = 1; step(); #1;
    // R1 reset state
    chk("R1", "flags", flags, 0); chk("R1", "cfgRdata", cfgRdata, 0);
    chk("R1", "irq", irq, 0); chk("R1", "pwmOut", pwmOut, PWM_A);

    phase = "R2";
    cfgWrite(8'hA5); #1 chk("R2", "cfgRdata", cfgRdata, 8'hA5);
    cfgWrite(8'h80); #1 chk("R2", "cfgRdata bit7", cfgRdata, 8'h80);

    // R3/R4/R5/R6 with fault pin 0 in auto mode, bit 7 set (R2 no effect)
    phase = "R3";
    faultIn0 = 1; step(); #1 chk("R3", "pwmOut one edge", pwmOut, PWM_A);
    phase = "R4";
    step(); #1 chk("R4", "pwmOut forced", pwmOut, SAFE);
    chk("R5", "flag not yet", flags, 0);
    step(); #1 chk("R5", "flag set", flags, 4'b0010);
    phase = "R6";
    faultIn0 = 0; step(2); #1 chk("R6", "still forced", pwmOut, SAFE);
    step(); #1 chk("R6", "auto release", pwmOut, PWM_A);
    chk("R5", "flag sticky", flags, 4'b0010);
    phase = "R5";
    clearFlags(4'b0010); #1 chk("R5", "flag cleared", flags, 0);

    phase = "R10";
    cfgWrite(8'h02);
    faultIn0 = 1; step(); faultIn0 = 0; step(3); #1 chk("R10", "irq f0", irq, 1);
    clearFlags(4'b0100); #1 chk("R10", "irq held", irq, 1);
    clearFlags(4'b0010); #1 chk("R10", "irq cleared", irq, 0);
    step(3);
    cfgWrite(8'h08);
    cmpTrip = 1; step(); cmpTrip = 0; step(3); #1 chk("R10", "irq cmp", irq, 1);
    clearFlags(4'b1000); step(3);
    cfgWrite(8'h2A);
    dbgHalt = 1; step(); dbgHalt = 0; step(3); #1
    chk("R10", "debug flag", flags, 4'b0001); chk("R10", "debug no irq", irq, 0);
    periodStart = 1; step(); periodStart = 0;
    clearFlags(4'b0001); step(2);

    phase = "R7";
    cfgWrite(8'h00);
    dbgHalt = 1; step(); dbgHalt = 0; step(8); #1 chk("R7", "debug waits period", pwmOut, SAFE);
    periodStart = 1; step(); periodStart = 0; #1 chk("R7", "period release", pwmOut, PWM_A);
    clearFlags(4'b0001); step(2);

    phase = "R8";
    cfgWrite(8'h01);
    faultIn0 = 1; step(); faultIn0 = 0; step(6);
    reloadStrobe = 1; step(); reloadStrobe = 0; #1 chk("R8", "reload with flags set", pwmOut, SAFE);
    clearFlags(4'b0010); step(3); #1 chk("R8", "no reload yet", pwmOut, SAFE);
    reloadStrobe = 1; step(); reloadStrobe = 0; #1 chk("R8", "reload release", pwmOut, PWM_A);

    phase = "R9";
    faultIn0 = 1; faultIn1 = 1; step(); faultIn0 = 0; faultIn1 = 0; step(6);
    cfgWrite(8'h00); step(3); #1 chk("R9", "mixed stays forced", pwmOut, SAFE);
    clearFlags(4'b0110); step(2); #1 chk("R9", "needs reload", pwmOut, SAFE);
    reloadStrobe = 1; step(); reloadStrobe = 0; #1 chk("R9", "reload release", pwmOut, PWM_A);

    phase = "R4/R5/R6/R7/R8/R10 random";
    for (int i = 0; i < 3000; i++) begin
      step();
      if ($urandom % 12 == 0) dbgHalt = ~dbgHalt;
      if ($urandom % 10 == 0) faultIn0 = ~faultIn0;
      if ($urandom % 10 == 0) faultIn1 = ~faultIn1;
      if ($urandom % 14 == 0) cmpTrip = ~cmpTrip;
      if ($urandom % 3 == 0) begin dbgHalt = 0; faultIn0 = 0; faultIn1 = 0; cmpTrip = 0; end
      periodStart  = ($urandom % 8 == 0);
      reloadStrobe = ($urandom % 6 == 0);
      clrWe   = ($urandom % 5 == 0);
      clrMask = 4'($urandom);
      cfgWe   = ($urandom % 40 == 0);
      cfgWdata = 8'($urandom);
      pwmIn   = OUT_W'($urandom);
    end
    step(); dbgHalt = 0; faultIn0 = 0; faultIn1 = 0; cmpTrip = 0;
    clrWe = 0; cfgWe = 0; periodStart = 0; reloadStrobe = 0;
    step(5);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule